// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Buffered Compare

This block is a 16-bit timer that counts up from zero to a ceiling value and then back down to zero, over and over. A single compare channel turns that triangle count into a pulse-width-modulated waveform. The waveform is centred on the peak of the triangle, so each pulse is symmetric about the middle of its period.

The ceiling comes from one of two places. It can be a period register that takes effect the moment it is written. It can instead be the compare register itself. The compare value is written into a shadow copy and is moved into the working copy only while the count sits at zero. Because of this, both slopes of a period always use the same threshold, even when software changes the duty cycle or the period while the timer runs. A prescaler sets how many clocks make one count step. A two-bit mode field selects one of four output behaviours: disconnected, toggle, non-inverted or inverted. Software reaches all settings through one synchronous write port.

Top module: `dual_slope_pwm`

## Requirements
- R1: While the timer runs, the count changes by exactly one on each prescaler tick. It rises from 0 to the ceiling, and in the same update that reaches the ceiling `count_down` goes to 1. It then falls back to 0, and in the update that reaches 0 `count_down` returns to 0. The count and `count_down` change on the clock edge that consumes the tick.
- R2: Control bit 3 selects the ceiling. 0 uses the period register. 1 uses the working compare value.
- R3: A write to the compare register (address 1) lands in a shadow copy. The working copy takes the shadow value on each clock edge that ends a cycle in which the count is 0. A shadow write made at any other time leaves the output of the period in progress unchanged.
- R4: A write to the period register (address 2) changes the ceiling on the next clock edge, inside the period in progress.
- R5: Control bits [2:0] select the clock divide. Codes 1, 2, 3, 4 and 5 give one tick every 1, 8, 64, 256 and 1024 clocks. Codes 0, 6 and 7 stop the timer, freeze the count and clear the prescaler. The period is 2·N·TOP clocks.
- R6: Mode 2 (non-inverted) drives `pwm_out` high while the count is below the working compare value. Mode 3 drives the inverse. In both modes `pwm_out` follows the counter state with a lag of one clock.
- R7: In mode 2, a compare value of 0 holds `pwm_out` low for the whole period. A compare value equal to or above the ceiling holds it high for the whole period. Mode 3 gives the opposite levels.
- R8: Mode 1 inverts `pwm_out` one clock after a tick brings the count onto the working compare value. When the ceiling comes from the compare value, the result is a 50% square wave with a period of 4·N·TOP clocks.
- R9: Mode 0 sets `pwm_oe` to 0 and `pwm_out` keeps its last level. Modes 1 to 3 set `pwm_oe` to 1.
- R10: `at_bottom` is high for one clock, in the first cycle the count is 0 after falling. `at_top` is high for one clock, in the first cycle the count equals the ceiling after rising.
- R11: After reset the count is 0 and rising, `pwm_out`, `pwm_oe`, `at_bottom` and `at_top` are 0, and every register is 0.
- R12: The control register is at address 0, with bits [2:0] the clock select, bit 3 the ceiling source and bits [5:4] the output mode. Address 1 is the compare shadow and address 2 the period register. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | W | Write data |
| pwm_out | output | 1 | Compare output level |
| pwm_oe | output | 1 | 1 when the output mode is not disconnected |
| count | output | W | Current counter value |
| count_down | output | 1 | 1 while the counter is descending |
| at_bottom | output | 1 | One-clock pulse on arrival at zero |
| at_top | output | 1 | One-clock pulse on arrival at the ceiling |

## Verification
The count, `count_down` and both arrival pulses are due on the clock edge that consumes a tick. `pwm_out` is due one edge later, because it reflects the counter state of the previous cycle. A shadow compare write reaches the working copy on the first edge that ends a cycle at zero, and a period write acts on the next edge. The bench advances a behavioural model on each rising edge using the same inputs and compares every output at the falling edge. Its directed window counts (period length, high time, levels held) start at an `at_bottom` pulse and skip the first period after any setting change, so that the one-clock output lag and the pending shadow load cannot distort them.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

   // Output behaviour selected by control bits [5:4]
   typedef enum logic [1:0] {
      OUT_OFF    = 2'd0,
      OUT_TOGGLE = 2'd1,
      OUT_NONINV = 2'd2,
      OUT_INV    = 2'd3
   } out_mode_e;

   // Register addresses on the write port
   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_CMP  = 2'd1;
   localparam logic [1:0] ADR_PER  = 2'd2;

   // Control field positions
   localparam int CSEL_LSB = 0;
   localparam int CSEL_W   = 3;
   localparam int TSRC_BIT = 3;
   localparam int MODE_LSB = 4;

   // Widest prescale divide is 2**PRE_W
   localparam int PRE_W = 10;

   // log2 of the divide for each clock-select code, -1 = stopped
   function automatic int sel_shift(input int code);
      case (code)
         1:       return 0;
         2:       return 3;
         3:       return 6;
         4:       return 8;
         5:       return 10;
         default: return -1;
      endcase
   endfunction

endpackage

// File: rtl/dsp_prescaler.sv
module dsp_prescaler
   import dsp_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CSEL_W-1:0] clk_sel,
   output logic              tick
);
   localparam int NCODES = 1 << CSEL_W;

   logic [PRE_W-1:0] lim_tbl [NCODES];
   logic             run_tbl [NCODES];
   logic [PRE_W-1:0] div_cnt;
   logic [PRE_W-1:0] limit;
   logic             running;

   // one terminal-count entry per clock-select code
   for (genvar g = 0; g < NCODES; g++) begin : g_code
      if (sel_shift(g) >= 0) begin : g_run
         assign lim_tbl[g] = PRE_W'((1 << sel_shift(g)) - 1);
         assign run_tbl[g] = 1'b1;
      end else begin : g_stop
         assign lim_tbl[g] = '0;
         assign run_tbl[g] = 1'b0;
      end
   end

   assign limit   = lim_tbl[clk_sel];
   assign running = run_tbl[clk_sel];
   assign tick    = running && (div_cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                div_cnt <= '0;
      else if (!running || tick) div_cnt <= '0;
      else                       div_cnt <= div_cnt + 1'b1;
   end

endmodule

// File: rtl/dsp_regs.sv
module dsp_regs
   import dsp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [W-1:0]      wr_data,
   input  logic              cnt_zero,
   output logic [CSEL_W-1:0] clk_sel,
   output logic              top_src,
   output out_mode_e         mode,
   output logic [W-1:0]      cmp_act,
   output logic [W-1:0]      per_reg
);
   logic [W-1:0] cmp_shadow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_sel    <= '0;
         top_src    <= 1'b0;
         mode       <= OUT_OFF;
         cmp_shadow <= '0;
         per_reg    <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            ADR_CTRL: begin
               clk_sel <= wr_data[CSEL_LSB +: CSEL_W];
               top_src <= wr_data[TSRC_BIT];
               mode    <= out_mode_e'(wr_data[MODE_LSB +: 2]);
            end
            ADR_CMP: cmp_shadow <= wr_data;
            ADR_PER: per_reg    <= wr_data;
            default: ;
         endcase
      end
   end

   // working compare copy follows the shadow only while the count rests at zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmp_act <= '0;
      else if (cnt_zero) cmp_act <= cmp_shadow;
   end

endmodule

// File: rtl/dsp_updown.sv
module dsp_updown #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] top,
   output logic [W-1:0] cnt,
   output logic         down,
   output logic         hit_bottom,
   output logic         hit_top
);
   localparam logic [W-1:0] ONE = W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         down       <= 1'b0;
         hit_bottom <= 1'b0;
         hit_top    <= 1'b0;
      end else begin
         hit_bottom <= 1'b0;
         hit_top    <= 1'b0;
         if (tick) begin
            if (top == '0) begin
               cnt  <= '0;
               down <= 1'b0;
            end else if (!down) begin
               if (cnt >= top) begin
                  // ceiling lowered below the count: turn round at once
                  cnt  <= cnt - ONE;
                  down <= 1'b1;
               end else begin
                  cnt <= cnt + ONE;
                  if (cnt + ONE == top) begin
                     down    <= 1'b1;
                     hit_top <= 1'b1;
                  end
               end
            end else begin
               if (cnt <= ONE) begin
                  cnt        <= '0;
                  down       <= 1'b0;
                  hit_bottom <= (cnt == ONE);
               end else begin
                  cnt <= cnt - ONE;
               end
            end
         end
      end
   end

endmodule

// File: rtl/dsp_outunit.sv
module dsp_outunit
   import dsp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  out_mode_e    mode,
   input  logic         tick,
   input  logic [W-1:0] cnt,
   input  logic [W-1:0] cmp,
   input  logic [W-1:0] top,
   output logic         pwm,
   output logic         oe
);
   logic tick_d;
   logic below;

   // ceiling-or-above compare pins the level high
   assign below = (cnt < cmp) || (cmp >= top);
   assign oe    = (mode != OUT_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_d <= 1'b0;
         pwm    <= 1'b0;
      end else begin
         tick_d <= tick;
         case (mode)
            OUT_TOGGLE: if (tick_d && (cnt == cmp)) pwm <= ~pwm;
            OUT_NONINV: pwm <= below;
            OUT_INV:    pwm <= ~below;
            default:    ;
         endcase
      end
   end

endmodule

// File: rtl/dual_slope_pwm.sv
module dual_slope_pwm
   import dsp_pkg::*;
#(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [1:0]   wr_addr,
   input  logic [W-1:0] wr_data,
   output logic         pwm_out,
   output logic         pwm_oe,
   output logic [W-1:0] count,
   output logic         count_down,
   output logic         at_bottom,
   output logic         at_top
);
   if (W < MODE_LSB + 2 || W > 32) begin : g_bad_width
      $error("dual_slope_pwm: W out of range");
   end

   logic [CSEL_W-1:0] clk_sel;
   logic              top_src;
   out_mode_e         mode;
   logic [W-1:0]      cmp_act;
   logic [W-1:0]      per_reg;
   logic [W-1:0]      top_val;
   logic              tick;

   assign top_val = top_src ? cmp_act : per_reg;

   dsp_prescaler u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clk_sel (clk_sel),
      .tick    (tick)
   );

   dsp_regs #(.W(W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .cnt_zero (count == '0),
      .clk_sel  (clk_sel),
      .top_src  (top_src),
      .mode     (mode),
      .cmp_act  (cmp_act),
      .per_reg  (per_reg)
   );

   dsp_updown #(.W(W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .top        (top_val),
      .cnt        (count),
      .down       (count_down),
      .hit_bottom (at_bottom),
      .hit_top    (at_top)
   );

   dsp_outunit #(.W(W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .tick  (tick),
      .cnt   (count),
      .cmp   (cmp_act),
      .top   (top_val),
      .pwm   (pwm_out),
      .oe    (pwm_oe)
   );

endmodule

// File: rtl/dsp_checker.sv
module dsp_checker #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] count,
   input logic         count_down,
   input logic         at_bottom,
   input logic         at_top,
   input logic         pwm_out,
   input logic         pwm_oe,
   input logic [W-1:0] cmp_act,
   input logic [2:0]   clk_sel
);
   // R1
   unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count) |-> (count == $past(count) + 1'b1 || count == $past(count) - 1'b1));

   // R10
   bottom_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_bottom |-> (count == '0 && !count_down));

   // R10
   top_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      at_top |-> count_down);

   // R10
   flags_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({at_bottom, at_top}));

   // R3
   cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count != '0) |=> $stable(cmp_act));

   // R5
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == 3'd0) |=> $stable(count));

   // R9
   off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_oe |=> $stable(pwm_out));

endmodule

bind dual_slope_pwm dsp_checker #(.W(W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .count      (count),
   .count_down (count_down),
   .at_bottom  (at_bottom),
   .at_top     (at_top),
   .pwm_out    (pwm_out),
   .pwm_oe     (pwm_oe),
   .cmp_act    (cmp_act),
   .clk_sel    (clk_sel)
);

// File: tb/dual_slope_pwm_test.sv
module dual_slope_pwm_test;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         pwm_out, pwm_oe, count_down, at_bottom, at_top;
   logic [W-1:0] count;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit done = 0;

   // behavioural reference state
   int m_cnt, m_up, m_pre, m_shadow, m_act, m_per, m_sel, m_tsrc, m_mode, m_oc, m_tickd, m_bot, m_topf;

   dual_slope_pwm #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .pwm_out(pwm_out), .pwm_oe(pwm_oe), .count(count), .count_down(count_down),
      .at_bottom(at_bottom), .at_top(at_top)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_up = 1; m_pre = 0; m_shadow = 0; m_act = 0; m_per = 0;
         m_sel = 0; m_tsrc = 0; m_mode = 0; m_oc = 0; m_tickd = 0; m_bot = 0; m_topf = 0;
      end else begin
         int lim, top, lvl, tk, nact;
         case (m_sel)
            1: lim = 0;
            2: lim = 7;
            3: lim = 63;
            4: lim = 255;
            5: lim = 1023;
            default: lim = -1;
         endcase
         tk  = (lim >= 0 && m_pre >= lim) ? 1 : 0;
         top = m_tsrc ? m_act : m_per;
         lvl = (m_cnt < m_act || m_act >= top) ? 1 : 0;
         case (m_mode)
            1: if (m_tickd && m_cnt == m_act) m_oc = 1 - m_oc;
            2: m_oc = lvl;
            3: m_oc = 1 - lvl;
            default: ;
         endcase
         nact = (m_cnt == 0) ? m_shadow : m_act;
         if (wr_en) begin
            case (wr_addr)
               0: begin m_sel = wr_data & 7; m_tsrc = (wr_data >> 3) & 1; m_mode = (wr_data >> 4) & 3; end
               1: m_shadow = wr_data;
               2: m_per = wr_data;
               default: ;
            endcase
         end
         m_bot = 0; m_topf = 0;
         if (tk) begin
            if (top == 0) begin m_cnt = 0; m_up = 1; end
            else if (m_up) begin
               if (m_cnt >= top) begin m_cnt--; m_up = 0; end
               else begin m_cnt++; if (m_cnt == top) begin m_up = 0; m_topf = 1; end end
            end else begin
               if (m_cnt <= 1) begin m_bot = (m_cnt == 1); m_cnt = 0; m_up = 1; end
               else m_cnt--;
            end
         end
         m_pre   = (lim < 0 || tk) ? 0 : m_pre + 1;
         m_tickd = tk;
         m_act   = nact;
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R1 count", int'(count), m_cnt);
         chk("R1 count_down", int'(count_down), 1 - m_up);
         chk("R6 pwm_out", int'(pwm_out), m_oc);
         chk("R9 pwm_oe", int'(pwm_oe), (m_mode != 0) ? 1 : 0);
         chk("R10 at_bottom", int'(at_bottom), m_bot);
         chk("R10 at_top", int'(at_top), m_topf);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         failures++;
         $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 100000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk); #1;
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = W'(d);
      @(negedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic wait_bottom();
      do @(negedge clk); while (!at_bottom);
   endtask

   task automatic wait_top();
      do @(negedge clk); while (!at_top);
   endtask

   // one full period from a bottom pulse, after discarding one period
   task automatic measure(output int per, output int hi);
      wait_bottom();
      wait_bottom();
      per = 0; hi = 0;
      do begin
         if (pwm_out) hi++;
         per++;
         @(negedge clk);
      end while (!at_bottom);
   endtask

   initial begin
      int per, hi, lvl, c0, ok;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 count", int'(count), 0);
      chk("R11 count_down", int'(count_down), 0);
      chk("R11 pwm_out", int'(pwm_out), 0);
      chk("R11 pwm_oe", int'(pwm_oe), 0);
      chk("R11 flags", int'({at_bottom, at_top}), 0);
      #1 rst_n = 1'b1;

      // R12 map, R5 divide 1, R6 non-inverted
      wr(2, 6); wr(1, 2); wr(0, 'h21);
      measure(per, hi);
      chk("R5 period div1", per, 12);
      chk("R6 high time mode2", hi, 3);
      wait_top();
      chk("R1 peak value", int'(count), 6);

      // R6 inverted
      wr(0, 'h31);
      measure(per, hi);
      chk("R6 high time mode3", hi, 9);

      // R7 extremes
      wr(0, 'h21); wr(1, 0);
      measure(per, hi);
      chk("R7 cmp zero low", hi, 0);
      wr(1, 6);
      measure(per, hi);
      chk("R7 cmp at top high", hi, 12);
      wr(1, 9);
      measure(per, hi);
      chk("R7 cmp above top high", hi, 12);
      wr(0, 'h31);
      measure(per, hi);
      chk("R7 inverted cmp above top low", hi, 0);
      wr(0, 'h21); wr(1, 2);
      measure(per, hi);

      // R3 shadow write on the falling slope has no effect this period
      wait_top();
      hi = pwm_out;
      #1; wr_en = 1'b1; wr_addr = 2'd1; wr_data = W'(4);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         hi += pwm_out;
         if (i == 0) begin #1; wr_en = 1'b0; end
      end
      chk("R3 old compare holds on falling slope", hi, 0);
      measure(per, hi);
      chk("R3 new compare after bottom", hi, 7);

      // R4 period register acts at once
      wait_bottom();
      wr(2, 10);
      wait_top();
      chk("R4 new ceiling same period", int'(count), 10);

      // R2 ceiling from compare, R8 toggle
      wr(1, 5);
      wait_bottom(); wait_bottom();
      wr(0, 'h19);
      wait_top();
      chk("R2 ceiling from compare", int'(count), 5);
      wait_bottom(); wait_bottom();
      lvl = pwm_out;
      do begin lvl = pwm_out; @(negedge clk); end while (!(pwm_out && !lvl));
      per = 0; hi = 0; lvl = 1;
      do begin
         if (pwm_out) hi++;
         per++;
         lvl = pwm_out;
         @(negedge clk);
      end while (!(pwm_out && !lvl));
      chk("R8 toggle period", per, 20);
      chk("R8 toggle duty", hi, 10);

      // R5 divide 8
      wr(1, 1); wr(2, 3); wr(0, 'h22);
      measure(per, hi);
      chk("R5 period div8", per, 48);
      chk("R6 high time div8", hi, 8);

      // R5 divide 1024
      wr(0, 'h25); wr(2, 1);
      measure(per, hi);
      chk("R5 period div1024", per, 2048);
      chk("R7 high throughout div1024", hi, 2048);

      // R12 address 3 ignored
      wr(0, 'h21); wr(2, 6); wr(1, 2); wr(3, 'hFFFF);
      measure(per, hi);
      chk("R12 period after addr3 write", per, 12);
      chk("R12 high time after addr3 write", hi, 3);

      // R9 disconnected holds level
      wr(0, 'h01);
      lvl = pwm_out; ok = 1;
      repeat (30) begin
         @(negedge clk);
         if (pwm_out != lvl[0] || pwm_oe) ok = 0;
      end
      chk("R9 level held with oe low", ok, 1);

      // R5 stop freezes count
      wr(0, 'h00);
      c0 = count; ok = 1;
      repeat (20) begin
         @(negedge clk);
         if (int'(count) != c0) ok = 0;
      end
      chk("R5 count frozen when stopped", ok, 1);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule